// File: doc/BRIEF.md
# Master-Mode Audio Bit and Frame Clock Generator

This block runs on the master clock of a stereo audio serial port. When the port is strapped as clock master, it divides that clock down to a bit clock and a left/right word clock. The division ratio comes from a two-bit sample-rate strap. Single and dual rate use a master clock of 256 times the sample rate, so the bit clock is the master clock divided by four. Quad rate uses 128 times the sample rate, so the bit clock is the master clock divided by two. In every case a frame is 64 bit-clock periods long.

A two-bit format strap selects the shape of the word clock. The right-justified and left-justified formats get a 50% square wave that is high in the first half of the frame. I2S gets a 50% square wave that is low in the first half. DSP gets a pulse that is high for the first bit period of the frame only. Every bit period begins with a falling edge of the bit clock, and the word clock changes only on those edges. A one-cycle frame-start strobe tells the serial transmitter that bit 0 of a frame has just begun.

The rate code 11 is not valid. While it is present, the clocks stop with both held low and an error flag is raised. Leaving reset, leaving the invalid code or re-entering master mode always begins a fresh frame at bit 0.

Top module: `aclk_master_gen`

## Requirements
- R1: While `rst` is high at a clock edge, all outputs are low after that edge. The reset is synchronous.
- R2: With `rate_sel` 00 (single) or 01 (dual), `bclk` has a period of 4 clocks: low for 2, then high for 2.
- R3: With `rate_sel` 10 (quad), `bclk` has a period of 2 clocks: low for 1, then high for 1.
- R4: With `fmt_sel` 00 (right justified) or 01 (left justified), `lrclk` is high during bit periods 0 to 31 of the 64-bit frame and low during bit periods 32 to 63.
- R5: With `fmt_sel` 10 (I2S), `lrclk` is low during bit periods 0 to 31 and high during bit periods 32 to 63.
- R6: With `fmt_sel` 11 (DSP), `lrclk` is high during bit period 0 only.
- R7: `frame_start` is high for exactly the one clock in which bit period 0 begins, that is, the clock in which `bclk` falls for bit 0. It therefore repeats every 256 clocks at single or dual rate and every 128 clocks at quad rate.
- R8: While `rate_sel` is 11, `bclk`, `lrclk` and `frame_start` are held low. `rate_err` is high one clock after 11 is sampled, and low one clock after any other code is sampled.
- R9: While `master_en` is low, `bclk`, `lrclk` and `frame_start` are held low.
- R10: The first clock of activity after reset, after an invalid rate code or after `master_en` rises is bit 0 with `div` 0 and `frame_start` high.
- R11: While `fmt_sel` is steady, `lrclk` changes only in clocks in which `bclk` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master audio clock |
| rst | input | 1 | Synchronous reset, active high |
| master_en | input | 1 | 1 = generate clocks (master), 0 = hold them low |
| rate_sel | input | 2 | 00 single, 01 dual, 10 quad, 11 invalid |
| fmt_sel | input | 2 | 00 right justified, 01 left justified, 10 I2S, 11 DSP |
| bclk | output | 1 | Generated bit clock |
| lrclk | output | 1 | Generated word clock or frame pulse |
| frame_start | output | 1 | One-clock strobe at the start of each frame |
| rate_err | output | 1 | High while the invalid rate code is applied |

## Verification
The bench targets three kinds of corner case:
- **Rate change mid-frame.** The bench switches from single to quad rate in the middle of a frame. The divider position can then lie beyond the new limit. A design that compared for equality instead of greater-or-equal would run through a long wrap and produce a stretched bit clock.
- **Restart after a stop.** The bench restarts from reset, from the invalid code and from a low mode strap. A generator that resumed from a stale position would miss the frame-start strobe, or would start the frame with the wrong word-clock level.
- **Word-clock shape and timing per format.** For each format the bench checks the half-frame boundary at bit 32 and the one-bit DSP pulse. An inverted polarity, an off-by-one width, or a word clock that changes while the bit clock is high would each show up as a mismatch against the per-clock model.

// File: rtl/aclk_pkg.sv
package aclk_pkg;

    typedef enum logic [1:0] {
        RATE_SINGLE = 2'b00,
        RATE_DUAL   = 2'b01,
        RATE_QUAD   = 2'b10,
        RATE_BAD    = 2'b11
    } rate_e;

    typedef enum logic [1:0] {
        FMT_RJ  = 2'b00,
        FMT_LJ  = 2'b01,
        FMT_I2S = 2'b10,
        FMT_DSP = 2'b11
    } fmt_e;

endpackage

// File: rtl/aclk_rate_decode.sv
module aclk_rate_decode #(
    parameter int SLOW_DIV = 4,
    parameter int FAST_DIV = 2,
    parameter int DIV_W    = 2
) (
    input  logic [1:0]       rate_sel,
    output logic [DIV_W-1:0] div_last,
    output logic [DIV_W-1:0] div_half,
    output logic             rate_ok
);
    import aclk_pkg::*;

    always_comb begin
        rate_ok  = 1'b1;
        div_last = DIV_W'(SLOW_DIV - 1);
        div_half = DIV_W'(SLOW_DIV / 2);
        case (rate_e'(rate_sel))
            RATE_SINGLE, RATE_DUAL: begin
                div_last = DIV_W'(SLOW_DIV - 1);
                div_half = DIV_W'(SLOW_DIV / 2);
            end
            RATE_QUAD: begin
                div_last = DIV_W'(FAST_DIV - 1);
                div_half = DIV_W'(FAST_DIV / 2);
            end
            default: rate_ok = 1'b0;
        endcase
    end

endmodule

// File: rtl/aclk_lr_shaper.sv
module aclk_lr_shaper #(
    parameter int FRAME_BITS = 64,
    parameter int BIT_W      = 6
) (
    input  logic [1:0]       fmt_sel,
    input  logic [BIT_W-1:0] bit_idx,
    output logic             lr_level
);
    import aclk_pkg::*;

    localparam logic [BIT_W-1:0] HALF = BIT_W'(FRAME_BITS / 2);

    always_comb begin
        case (fmt_e'(fmt_sel))
            FMT_DSP: lr_level = (bit_idx == '0);
            FMT_I2S: lr_level = (bit_idx >= HALF);
            default: lr_level = (bit_idx < HALF);
        endcase
    end

endmodule

// File: rtl/aclk_master_gen.sv
module aclk_master_gen #(
    parameter int FRAME_BITS = 64,
    parameter int SLOW_DIV   = 4,
    parameter int FAST_DIV   = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       master_en,
    input  logic [1:0] rate_sel,
    input  logic [1:0] fmt_sel,
    output logic       bclk,
    output logic       lrclk,
    output logic       frame_start,
    output logic       rate_err
);
    localparam int DIV_W = (SLOW_DIV > 2) ? $clog2(SLOW_DIV) : 1;
    localparam int BIT_W = $clog2(FRAME_BITS);
    localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(FRAME_BITS - 1);

    typedef struct packed {
        logic             run;
        logic [DIV_W-1:0] div;
        logic [BIT_W-1:0] bitn;
        logic             bclk;
        logic             lr;
        logic             fs;
        logic             err;
    } gen_state_t;

    gen_state_t st_d, st_q;

    logic [DIV_W-1:0] div_last;
    logic [DIV_W-1:0] div_half;
    logic             rate_ok;
    logic             lr_level;
    logic             active;

    aclk_rate_decode #(
        .SLOW_DIV (SLOW_DIV),
        .FAST_DIV (FAST_DIV),
        .DIV_W    (DIV_W)
    ) u_rate (
        .rate_sel (rate_sel),
        .div_last (div_last),
        .div_half (div_half),
        .rate_ok  (rate_ok)
    );

    aclk_lr_shaper #(
        .FRAME_BITS (FRAME_BITS),
        .BIT_W      (BIT_W)
    ) u_lr (
        .fmt_sel  (fmt_sel),
        .bit_idx  (st_d.bitn),
        .lr_level (lr_level)
    );

    assign active = master_en && rate_ok;

    always_comb begin
        st_d      = st_q;
        st_d.err  = (rate_sel == 2'b11);
        if (!active) begin
            st_d.run  = 1'b0;
            st_d.div  = '0;
            st_d.bitn = '0;
        end else if (!st_q.run) begin
            st_d.run  = 1'b1;
            st_d.div  = '0;
            st_d.bitn = '0;
        end else if (st_q.div >= div_last) begin
            st_d.div  = '0;
            st_d.bitn = (st_q.bitn == LAST_BIT) ? '0 : st_q.bitn + 1'b1;
        end else begin
            st_d.div  = st_q.div + 1'b1;
        end
        st_d.bclk = active && (st_d.div >= div_half);
        st_d.lr   = active && lr_level;
        st_d.fs   = active && (st_d.div == '0) && (st_d.bitn == '0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign bclk        = st_q.bclk;
    assign lrclk       = st_q.lr;
    assign frame_start = st_q.fs;
    assign rate_err    = st_q.err;

endmodule

// File: rtl/aclk_master_gen_chk.sv
module aclk_master_gen_chk (
    input logic       clk,
    input logic       rst,
    input logic       master_en,
    input logic [1:0] rate_sel,
    input logic [1:0] fmt_sel,
    input logic       bclk,
    input logic       lrclk,
    input logic       frame_start,
    input logic       rate_err
);

    AST_BAD_RATE_HALT: assert property (@(posedge clk) disable iff (rst)
        ($past(rate_sel) == 2'b11) |-> (!bclk && !lrclk && !frame_start)); // R8

    AST_BAD_RATE_FLAG: assert property (@(posedge clk) disable iff (rst)
        ($past(rate_sel) == 2'b11) |-> rate_err); // R8

    AST_SLAVE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !$past(master_en) |-> (!bclk && !lrclk && !frame_start)); // R9

    AST_FS_ON_LOW_BCLK: assert property (@(posedge clk) disable iff (rst)
        frame_start |-> !bclk); // R7

    AST_FS_SINGLE: assert property (@(posedge clk) disable iff (rst)
        frame_start |=> !frame_start); // R7

    AST_LR_AT_FALL: assert property (@(posedge clk) disable iff (rst)
        (!$stable(lrclk) && ($past(fmt_sel) == $past(fmt_sel, 2))) |-> !bclk); // R11

endmodule

bind aclk_master_gen aclk_master_gen_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .master_en   (master_en),
    .rate_sel    (rate_sel),
    .fmt_sel     (fmt_sel),
    .bclk        (bclk),
    .lrclk       (lrclk),
    .frame_start (frame_start),
    .rate_err    (rate_err)
);

// File: tb/aclk_master_gen_tb.sv
`timescale 1ns/1ps
module aclk_master_gen_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       master_en = 1'b1;
    logic [1:0] rate_sel = 2'b00;
    logic [1:0] fmt_sel = 2'b01;
    logic       bclk, lrclk, frame_start, rate_err;

    int tests = 0;
    int fails = 0;
    bit done = 0;

    always #10 clk = ~clk;

    aclk_master_gen u_dut (
        .clk         (clk),
        .rst         (rst),
        .master_en   (master_en),
        .rate_sel    (rate_sel),
        .fmt_sel     (fmt_sel),
        .bclk        (bclk),
        .lrclk       (lrclk),
        .frame_start (frame_start),
        .rate_err    (rate_err)
    );

    // behavioural reference model
    bit    m_run = 0;
    int    m_div = 0;
    int    m_bit = 0;
    int    divn;
    bit    e_b = 0, e_l = 0, e_f = 0, e_err = 0;
    bit    fmt_steady = 0;
    logic [1:0] fmt_seen = 2'b01;
    string tag_b = "R1", tag_l = "R1", tag_f = "R1", tag_e = "R1";

    always @(posedge clk) begin
        fmt_steady = (fmt_sel == fmt_seen);
        fmt_seen   = fmt_sel;
        if (rst) begin
            m_run = 0; m_div = 0; m_bit = 0;
            e_b = 0; e_l = 0; e_f = 0; e_err = 0;
            tag_b = "R1"; tag_l = "R1"; tag_f = "R1"; tag_e = "R1";
        end else if (!master_en || rate_sel == 2'b11) begin
            m_run = 0; m_div = 0; m_bit = 0;
            e_b = 0; e_l = 0; e_f = 0;
            e_err = (rate_sel == 2'b11);
            tag_b = (rate_sel == 2'b11) ? "R8" : "R9";
            tag_l = tag_b; tag_f = tag_b; tag_e = "R8";
        end else begin
            divn = (rate_sel == 2'b10) ? 2 : 4;
            tag_f = m_run ? "R7" : "R10";
            if (!m_run) begin
                m_run = 1; m_div = 0; m_bit = 0;
            end else begin
                m_div++;
                if (m_div >= divn) begin
                    m_div = 0;
                    m_bit = (m_bit + 1) % 64;
                end
            end
            e_b   = (m_div >= divn / 2);
            e_l   = (fmt_sel == 2'b11) ? (m_bit == 0) :
                    (fmt_sel == 2'b10) ? (m_bit >= 32) : (m_bit < 32);
            e_f   = (m_div == 0) && (m_bit == 0);
            e_err = 0;
            tag_b = (divn == 2) ? "R3" : "R2";
            tag_l = (fmt_sel == 2'b11) ? "R6" : (fmt_sel == 2'b10) ? "R5" : "R4";
            tag_e = "R8";
        end
    end

    task automatic chk(input string tag, input string what, input logic act, input logic exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%b expected=%b at %0t", tag, what, act, exp, $time);
        end
    endtask

    logic lr_prev = 1'b0;
    always @(negedge clk) begin
        if (!done) begin
            chk(tag_b, "bclk", bclk, e_b);
            chk(tag_l, "lrclk", lrclk, e_l);
            chk(tag_f, "frame_start", frame_start, e_f);
            chk(tag_e, "rate_err", rate_err, e_err);
            if (lrclk !== lr_prev && fmt_steady && !rst)
                chk("R11", "bclk at lrclk change", bclk, 1'b0);
            lr_prev = lrclk;
        end
    end

    task automatic run_cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1;
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    endtask

    initial begin
        run_cycles(5);
        rst = 1'b0;
        run_cycles(600);          // single rate, left justified
        fmt_sel = 2'b00;
        run_cycles(300);          // right justified
        rate_sel = 2'b01; fmt_sel = 2'b10;
        run_cycles(550);          // dual rate, I2S
        rate_sel = 2'b10;
        run_cycles(301);          // quad entered mid-frame
        fmt_sel = 2'b11;
        run_cycles(300);          // quad DSP
        rate_sel = 2'b11;
        run_cycles(20);           // invalid code
        rate_sel = 2'b10; fmt_sel = 2'b00;
        run_cycles(200);
        master_en = 1'b0;
        run_cycles(20);
        master_en = 1'b1; rate_sel = 2'b00; fmt_sel = 2'b11;
        run_cycles(600);          // single DSP
        rst = 1'b1;
        run_cycles(3);
        rst = 1'b0; fmt_sel = 2'b10;
        run_cycles(300);
        finish_run();
    end

    initial begin
        #(20 * 200000);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

endmodule